// File: doc/BRIEF.md
# Two-Packet Straddling Stream Packer

This block takes completion packets arriving one Dword per cycle and packs them onto a 16-Dword output beat. Each packet is a fixed 3-Dword descriptor followed at once by its payload, and the producer marks its first and last Dwords. A packet that does not fit in one beat carries on from Dword 0 of the next beat. A beat can hold two packets. When the packet in flight ends in the lower half of a beat (Dword 7 or below), the next packet may begin at Dword 8 of the same beat.

With every beat the block reports where packets start and where they end. Two start flags and a 2-bit start pointer for each show the start positions. Two end flags and a 4-bit last-Dword pointer for each show the end positions. A 4-bit keep mask for each Dword marks the lanes that carry data. The output is a registered valid/ready stage that holds its contents while the consumer stalls. A downstream packet engine can therefore take up to two packets per beat without realigning them.

Top module: `strad_packer`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0. In the first cycle after reset, `in_ready` is 1.
- R2: Each beat starts with a filled Dword 0, either a continuing packet or a new one. Dwords of a packet occupy consecutive lanes with no gap, so the payload comes straight after the descriptor. Every carried Dword has keep value 4'hF. Every padding lane has keep 4'h0 and data zero.
- R3: A packet begins at Dword 8 only under two conditions. The previous packet must have ended at Dword 7 or below in the same beat. The new packet's first Dword must also be offered in the cycle right after that end Dword is accepted. Otherwise the beat is closed with padding and the next packet starts at Dword 0 of a new beat. A beat also closes once Dword 15 is filled or once a packet ends at Dword 8 or above.
- R4: `out_sop[0]` is set when at least one packet starts in the beat. `out_sop0_ptr` is 2'b00 for a start at Dword 0 and 2'b10 for a start at Dword 8. `out_sop[1]` is set when a second packet starts in the beat, and `out_sop1_ptr` is then 2'b10.
- R5: `out_eop[0]` is set when at least one packet ends in the beat, and `out_eop0_ptr` is the lane index of that packet's last Dword. `out_eop[1]` with `out_eop1_ptr` reports a second ending packet the same way.
- R6: `out_eop[1]` is set only together with `out_eop[0]` and `out_sop[0]`, and `out_eop1_ptr` then lies in 10..15.
- R7: `out_sop[1]` is set only together with `out_sop[0]` at pointer 2'b00, and with `out_eop[0]` at a pointer of 7 or below.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values. Every beat is delivered exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input Dword offered |
| in_ready | output | 1 | Input Dword accepted this cycle when high together with in_valid |
| in_sop | input | 1 | First Dword of a packet |
| in_eop | input | 1 | Last Dword of a packet |
| in_data | input | 32 | Input Dword |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 512 | Beat data, lane i at bits 32*i+31..32*i |
| out_keep | output | 64 | Keep mask, 4 bits per lane |
| out_sop | output | 2 | Start flags |
| out_sop0_ptr | output | 2 | First start position (2'b00 or 2'b10) |
| out_sop1_ptr | output | 2 | Second start position (2'b10) |
| out_eop | output | 2 | End flags |
| out_eop0_ptr | output | 4 | Last lane of the first ending packet |
| out_eop1_ptr | output | 4 | Last lane of the second ending packet |

## Verification
The bench runs every pairing of payload lengths 0 to 12 back to back, then a set of long packets, with idle gaps inserted after some packets and a stall pattern on `out_ready`. This exercises packets that end exactly at Dword 7 and at Dword 8, a second packet that runs out at Dword 15, and continuation beats whose tail is followed by a new packet at Dword 8. A design that straddled after an end at Dword 8 would place the next packet in overlapping or shifted lanes. A design that waited indefinitely for a partner packet after a gap would hang the beat. A design that mislabelled a Dword-8 start in a continuation beat as the second start would give wrong flags, and a stall-unsafe output register would drop or repeat beats.

// File: rtl/strad_pkg.sv
package strad_pkg;

  // Assembly progress of the beat being built.
  typedef enum logic [1:0] {
    ST_FILL,  // taking Dwords into the current beat
    ST_HOLD,  // lower-half end seen, a partner packet may join at the half boundary
    ST_DONE   // beat complete, waiting for the output stage
  } asm_state_e;

  // Start pointer code for a start at the half-beat boundary.
  localparam logic [1:0] HALF_START_CODE = 2'b10;

endpackage

// File: rtl/strad_asm.sv
module strad_asm
  import strad_pkg::*;
#(
  parameter int DWORD_W = 32,
  parameter int NDW     = 16,
  parameter int PTR_W   = $clog2(NDW)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sop,
  input  logic                    in_eop,
  input  logic [DWORD_W-1:0]      in_data,
  input  logic                    take,
  output logic                    beat_rdy,
  output logic [NDW*DWORD_W-1:0]  beat_data,
  output logic [NDW*DWORD_W/8-1:0] beat_keep,
  output logic [1:0]              sop,
  output logic [1:0]              sop0_ptr,
  output logic [1:0]              sop1_ptr,
  output logic [1:0]              eop,
  output logic [PTR_W-1:0]        eop0_ptr,
  output logic [PTR_W-1:0]        eop1_ptr
);

  localparam int HALF = NDW / 2;
  localparam int BE_W = DWORD_W / 8;

  asm_state_e                    st;
  logic [PTR_W-1:0]              pos;
  logic [NDW-1:0]                fill;
  logic [NDW-1:0][DWORD_W-1:0]   dw_q;
  logic [PTR_W-1:0]              wp;
  logic                          acc;
  logic                          hold_miss;

  // Write lane: the half boundary while a partner may join, else the fill pointer.
  always_comb begin
    wp        = (st == ST_HOLD) ? PTR_W'(HALF) : pos;
    in_ready  = (st == ST_FILL) || ((st == ST_HOLD) && in_sop);
    acc       = in_valid && in_ready;
    hold_miss = (st == ST_HOLD) && !(in_valid && in_sop);
  end

  assign beat_rdy = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_FILL;
      pos      <= '0;
      fill     <= '0;
      sop      <= '0;
      sop0_ptr <= '0;
      sop1_ptr <= '0;
      eop      <= '0;
      eop0_ptr <= '0;
      eop1_ptr <= '0;
    end else if (st == ST_DONE) begin
      if (take) begin
        st       <= ST_FILL;
        pos      <= '0;
        fill     <= '0;
        sop      <= '0;
        sop0_ptr <= '0;
        sop1_ptr <= '0;
        eop      <= '0;
        eop0_ptr <= '0;
        eop1_ptr <= '0;
      end
    end else if (hold_miss) begin
      st <= ST_DONE;
    end else if (acc) begin
      fill[wp] <= 1'b1;
      pos      <= wp + 1'b1;
      st       <= ST_FILL;
      if (in_sop) begin
        if (wp == '0) begin
          sop[0]   <= 1'b1;
          sop0_ptr <= 2'b00;
        end else if (sop[0]) begin
          sop[1]   <= 1'b1;
          sop1_ptr <= HALF_START_CODE;
        end else begin
          sop[0]   <= 1'b1;
          sop0_ptr <= HALF_START_CODE;
        end
      end
      if (in_eop) begin
        if (!eop[0]) begin
          eop[0]   <= 1'b1;
          eop0_ptr <= wp;
        end else begin
          eop[1]   <= 1'b1;
          eop1_ptr <= wp;
        end
        st <= (wp < PTR_W'(HALF)) ? ST_HOLD : ST_DONE;
      end
      if (wp == PTR_W'(NDW-1)) st <= ST_DONE;
    end
  end

  // Lane storage without reset so it maps onto plain registers or RAM.
  always_ff @(posedge clk) begin
    if (acc) dw_q[wp] <= in_data;
  end

  for (genvar i = 0; i < NDW; i++) begin : g_lane
    assign beat_data[i*DWORD_W +: DWORD_W] = fill[i] ? dw_q[i] : '0;
    assign beat_keep[i*BE_W +: BE_W]       = {BE_W{fill[i]}};
  end

endmodule

// File: rtl/strad_outreg.sv
module strad_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         beat_rdy,
  output logic         take,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);

  assign take = beat_rdy && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (take)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) q <= d;
  end

endmodule

// File: rtl/strad_packer.sv
module strad_packer #(
  parameter int DWORD_W = 32,
  parameter int NDW     = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sop,
  input  logic                      in_eop,
  input  logic [DWORD_W-1:0]        in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NDW*DWORD_W-1:0]    out_data,
  output logic [NDW*DWORD_W/8-1:0]  out_keep,
  output logic [1:0]                out_sop,
  output logic [1:0]                out_sop0_ptr,
  output logic [1:0]                out_sop1_ptr,
  output logic [1:0]                out_eop,
  output logic [$clog2(NDW)-1:0]    out_eop0_ptr,
  output logic [$clog2(NDW)-1:0]    out_eop1_ptr
);

  localparam int PTR_W = $clog2(NDW);
  localparam int DAT_W = NDW * DWORD_W;
  localparam int KEP_W = NDW * DWORD_W / 8;
  localparam int FLG_W = 8 + 2 * PTR_W;
  localparam int PK_W  = DAT_W + KEP_W + FLG_W;

  logic              take;
  logic              beat_rdy;
  logic [DAT_W-1:0]  a_data;
  logic [KEP_W-1:0]  a_keep;
  logic [1:0]        a_sop, a_sop0, a_sop1, a_eop;
  logic [PTR_W-1:0]  a_eop0, a_eop1;
  logic [PK_W-1:0]   beat_pack, out_pack;

  strad_asm #(
    .DWORD_W (DWORD_W),
    .NDW     (NDW),
    .PTR_W   (PTR_W)
  ) asm_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_data  (in_data),
    .take     (take),
    .beat_rdy (beat_rdy),
    .beat_data(a_data),
    .beat_keep(a_keep),
    .sop      (a_sop),
    .sop0_ptr (a_sop0),
    .sop1_ptr (a_sop1),
    .eop      (a_eop),
    .eop0_ptr (a_eop0),
    .eop1_ptr (a_eop1)
  );

  assign beat_pack = {a_data, a_keep, a_sop, a_sop0, a_sop1, a_eop, a_eop0, a_eop1};

  strad_outreg #(
    .W (PK_W)
  ) oreg_i (
    .clk      (clk),
    .rst      (rst),
    .beat_rdy (beat_rdy),
    .take     (take),
    .d        (beat_pack),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q        (out_pack)
  );

  assign {out_data, out_keep, out_sop, out_sop0_ptr, out_sop1_ptr,
          out_eop, out_eop0_ptr, out_eop1_ptr} = out_pack;

endmodule

// File: rtl/strad_packer_chk.sv
module strad_packer_chk #(
  parameter int DWORD_W = 32,
  parameter int NDW     = 16,
  parameter int PTR_W   = $clog2(NDW)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [NDW*DWORD_W-1:0]    out_data,
  input logic [NDW*DWORD_W/8-1:0]  out_keep,
  input logic [1:0]                out_sop,
  input logic [1:0]                out_sop0_ptr,
  input logic [1:0]                out_sop1_ptr,
  input logic [1:0]                out_eop,
  input logic [PTR_W-1:0]          out_eop0_ptr,
  input logic [PTR_W-1:0]          out_eop1_ptr
);

  localparam int HALF = NDW / 2;
  localparam int BE_W = DWORD_W / 8;

  // R2: every delivered beat has lane 0 filled
  a_r2_lane0_filled: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_keep[BE_W-1:0] == {BE_W{1'b1}});

  // R3: a start at the half boundary follows a lower-half end and fills that lane
  a_r3_half_start: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop[0] && out_sop0_ptr == 2'b10)
      |-> (out_eop[0] && out_eop0_ptr < PTR_W'(HALF)
           && out_keep[HALF*BE_W +: BE_W] == {BE_W{1'b1}}));

  // R4: first start pointer takes only the two legal codes
  a_r4_start_code: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop[0]) |-> (out_sop0_ptr == 2'b00 || out_sop0_ptr == 2'b10));

  // R5: the reported last lane of the first ending packet carries data
  a_r5_end_lane_kept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eop[0]) |-> out_keep[{out_eop0_ptr, {$clog2(BE_W){1'b0}}}]);

  // R6: second end needs first end and a start, and lies in the upper range
  a_r6_second_end: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eop[1])
      |-> (out_eop[0] && out_sop[0] && out_eop1_ptr >= PTR_W'(HALF+2)
           && out_eop1_ptr > out_eop0_ptr));

  // R7: second start only after a lower-half end of a packet started at lane 0
  a_r7_second_start: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop[1])
      |-> (out_sop[0] && out_sop0_ptr == 2'b00 && out_sop1_ptr == 2'b10
           && out_eop[0] && out_eop0_ptr < PTR_W'(HALF)));

  // R8: a stalled beat holds every output
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready)
      |=> (out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_sop)
           && $stable(out_sop0_ptr) && $stable(out_sop1_ptr) && $stable(out_eop)
           && $stable(out_eop0_ptr) && $stable(out_eop1_ptr)));

endmodule

bind strad_packer strad_packer_chk #(
  .DWORD_W (DWORD_W),
  .NDW     (NDW),
  .PTR_W   (PTR_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_keep    (out_keep),
  .out_sop     (out_sop),
  .out_sop0_ptr(out_sop0_ptr),
  .out_sop1_ptr(out_sop1_ptr),
  .out_eop     (out_eop),
  .out_eop0_ptr(out_eop0_ptr),
  .out_eop1_ptr(out_eop1_ptr)
);

// File: tb/strad_packer_tb.sv
module strad_packer_tb_top;

  localparam int DWORD_W = 32;
  localparam int NDW     = 16;
  localparam int HALF    = 8;
  localparam int NPAIR   = 13;
  localparam int NPAIRED = NPAIR * NPAIR * 2;
  localparam int NLONG   = 6;
  localparam int NP      = NPAIRED + NLONG;
  localparam int MAXB    = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst;
  logic         in_valid, in_ready, in_sop, in_eop;
  logic [31:0]  in_data;
  logic         out_valid, out_ready;
  logic [511:0] out_data;
  logic [63:0]  out_keep;
  logic [1:0]   out_sop, out_sop0_ptr, out_sop1_ptr, out_eop;
  logic [3:0]   out_eop0_ptr, out_eop1_ptr;

  strad_packer #(.DWORD_W(DWORD_W), .NDW(NDW)) dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_sop(out_sop), .out_sop0_ptr(out_sop0_ptr),
    .out_sop1_ptr(out_sop1_ptr), .out_eop(out_eop), .out_eop0_ptr(out_eop0_ptr),
    .out_eop1_ptr(out_eop1_ptr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_exp = 0;
  int n_rx = 0;

  logic [511:0] exp_data [MAXB];
  logic [63:0]  exp_keep [MAXB];
  logic [5:0]   exp_sf   [MAXB];  // {sop, sop0_ptr, sop1_ptr}
  logic [9:0]   exp_ef   [MAXB];  // {eop, eop0_ptr, eop1_ptr}

  function automatic int pkt_len(int k);
    int pl;
    if (k < NPAIRED) pl = ((k % 2) == 0) ? (k / 2) / NPAIR : (k / 2) % NPAIR;
    else             pl = 13 + 7 * (k - NPAIRED);
    return 3 + pl;  // fixed 3-Dword descriptor plus payload
  endfunction

  function automatic bit pkt_gap(int k);
    return ((k % 5) == 3) || (k == NP - 1);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected beats from R2..R7: contiguous lanes, half-boundary partner rule, flag codes.
  task automatic build_model();
    int  pos;
    bit  hold;
    logic [1:0] s, s0, s1, e;
    logic [3:0] e0, e1;
    pos = 0; hold = 1'b0;
    s = '0; s0 = '0; s1 = '0; e = '0; e0 = '0; e1 = '0;
    for (int b = 0; b < MAXB; b++) begin
      exp_data[b] = '0; exp_keep[b] = '0; exp_sf[b] = '0; exp_ef[b] = '0;
    end
    for (int k = 0; k < NP; k++) begin
      int len;
      len = pkt_len(k);
      for (int d = 0; d < len; d++) begin
        int wp;
        bit close;
        if (d == 0 && hold) begin pos = HALF; hold = 1'b0; end
        wp = pos;
        exp_data[n_exp][wp*32 +: 32] = {16'(k), 16'(d)};
        exp_keep[n_exp][wp*4 +: 4]   = 4'hF;
        if (d == 0) begin
          if (wp == 0)    begin s[0] = 1'b1; s0 = 2'b00; end
          else if (s[0]) begin s[1] = 1'b1; s1 = 2'b10; end
          else            begin s[0] = 1'b1; s0 = 2'b10; end
        end
        close = 1'b0;
        if (d == len - 1) begin
          if (!e[0]) begin e[0] = 1'b1; e0 = 4'(wp); end
          else       begin e[1] = 1'b1; e1 = 4'(wp); end
          if (wp < HALF && !pkt_gap(k)) hold = 1'b1;
          else close = 1'b1;
        end
        if (wp == NDW - 1) close = 1'b1;
        pos = wp + 1;
        if (close) begin
          exp_sf[n_exp] = {s, s0, s1};
          exp_ef[n_exp] = {e, e0, e1};
          n_exp++;
          pos = 0; hold = 1'b0;
          s = '0; s0 = '0; s1 = '0; e = '0; e0 = '0; e1 = '0;
        end
      end
    end
  endtask

  task automatic send_all();
    for (int k = 0; k < NP; k++) begin
      int len;
      len = pkt_len(k);
      for (int d = 0; d < len; d++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = (d == 0);
        in_eop   = (d == len - 1);
        in_data  = {16'(k), 16'(d)};
        #1;
        while (!in_ready) begin
          @(negedge clk);
          #1;
        end
        @(posedge clk);
      end
      if (pkt_gap(k)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  // Output monitor: drives the stall pattern and scores delivered beats.
  int           cyc = 0;
  bit           stalled = 1'b0;
  logic [599:0] snap;
  initial begin
    out_ready = 1'b0;
    wait (rst === 1'b0);
    forever begin
      logic [599:0] now;
      @(negedge clk);
      cyc++;
      out_ready = !(((cyc % 7) == 3) || ((cyc % 11) == 5) || ((cyc % 97) >= 90));
      #2;
      now = {out_data, out_keep, out_sop, out_sop0_ptr, out_sop1_ptr,
             out_eop, out_eop0_ptr, out_eop1_ptr};
      if (stalled) begin
        check(out_valid && (now == snap), "R8", "stalled beat changed",
              512'(now[87:0]), 512'(snap[87:0]));
      end
      stalled = out_valid && !out_ready;
      if (stalled) snap = now;
      if (out_valid && out_ready) begin
        if (n_rx >= n_exp) begin
          check(1'b0, "R8", "extra beat", 512'(n_rx), 512'(n_exp));
        end else begin
          check(out_data == exp_data[n_rx], "R2 R3", "beat data", out_data, exp_data[n_rx]);
          check(out_keep == exp_keep[n_rx], "R2 R3", "keep mask",
                512'(out_keep), 512'(exp_keep[n_rx]));
          check({out_sop, out_sop0_ptr, out_sop1_ptr} == exp_sf[n_rx], "R4 R7", "start flags",
                512'({out_sop, out_sop0_ptr, out_sop1_ptr}), 512'(exp_sf[n_rx]));
          check({out_eop, out_eop0_ptr, out_eop1_ptr} == exp_ef[n_rx], "R5 R6", "end flags",
                512'({out_eop, out_eop0_ptr, out_eop1_ptr}), 512'(exp_ef[n_rx]));
        end
        n_rx++;
      end
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    build_model();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 512'(out_valid), 512'(0));
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R1", "in_ready after reset", 512'(in_ready), 512'(1));
    check(out_valid == 1'b0, "R1", "out_valid after reset", 512'(out_valid), 512'(0));
    fork
      begin
        send_all();
        wait (n_rx >= n_exp);
        repeat (40) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog expired: actual %0d beats expected %0d", n_rx, n_exp);
      end
    join_any
    disable fork;
    check(n_rx == n_exp, "R8", "beat count", 512'(n_rx), 512'(n_exp));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule